// File: doc/BRIEF.md
# Halt Wake-Up Controller

This block sits beside a processor core and owns the decision of when the core leaves a halted low-power state and what it does next. The core asks to halt with one of three depths: a light idle, a deeper idle, and a stop state in which the oscillator is switched off. While halted, the block watches the per-source interrupt pending flags, their priority levels, the current mask level and a non-maskable line. It decides whether a new request wakes the core, whether that request is serviced or the core simply resumes after the halt, and in what order requests are serviced.

Two behaviours set it apart from a plain wake gate. First, a designated set of wake-capable sources (by default five external lines and a real-time-clock source) can wake the core even when masked; the core then resumes without service and the source flag is left set for software. Second, for the two deeper modes there is a short entry window. A request that arrives during it does not wake the core but is parked in a hold slot. When a later request wakes the core, the two are serviced in priority order. A synchronous release reset ends any halt. When it ends a stop, the clock-stable output stays low until a warm-up down-counter expires. The vector fetch, the pipeline and the storage are outside the block. Settings held elsewhere are cleared by the same reset, and storage keeps its contents.

Top module: `halt_wake_ctrl`

## Requirements
- R1: A high `soft_rst` on a clock edge ends any halt. `halted` is low after that edge, and any held request or queued second service is discarded.
- R2: `halt_req` is taken only when the block is running and not warming up. `halted` is high after the accepting edge. `halt_mode` is encoded 0 = light idle, 1 = deep idle, 2 or 3 = stop.
- R3: While fully halted, a pending flag that newly rises with a level strictly greater than `mask_lvl` wakes the core. On that edge `wake_pulse` and `svc_strobe` go high for one cycle, `svc_id` carries the source index and `halted` falls.
- R4: While halted, a newly raised flag whose level is less than or equal to `mask_lvl` and whose source is not wake-capable has no effect. `halted` stays high and no strobe appears.
- R5: A rising `nmi` while fully halted always wakes the core and is serviced with `svc_id` equal to NUM_SRC (8 by default), whatever `mask_lvl` is, including 7.
- R6: A masked, newly raised wake-capable source (sources 0 to 5 by default) wakes the core with `wake_pulse` and `resume_nosvc` high for one cycle and no `svc_strobe`.
- R7: After a deep idle or stop request is taken, the block stays in an entry window for ENTRY_WIN cycles (5 by default). A request rising in the window does not wake the core and is held. A light idle has no window: a request on the cycle after acceptance already wakes the core.
- R8: When a new serviceable request wakes the core while a request is held, the higher-priority one is serviced on the wake edge and the other on the next edge.
- R9: Priority is the level, with the non-maskable line above every level. On equal level the lower source index wins. Of several requests rising together, only the winner is serviced.
- R10: `clk_stable` is low while fully halted in stop. After a `soft_rst` that ends a stop, it stays low until OSC_WAIT+1 (17 by default) edges after `soft_rst` falls. A reset that ends an idle mode leaves it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous release reset, active high |
| halt_req | input | 1 | Halt request from the core |
| halt_mode | input | 2 | Halt depth for the request |
| mask_lvl | input | LVL_W | Current interrupt mask level |
| irq_pend | input | NUM_SRC | Per-source pending flags |
| irq_lvl | input | NUM_SRC*LVL_W | Per-source request levels, source i at bits i*LVL_W upward |
| nmi | input | 1 | Non-maskable interrupt line |
| halted | output | 1 | Core is in the entry window or halted |
| wake_pulse | output | 1 | One-cycle wake indication |
| svc_strobe | output | 1 | One-cycle service strobe |
| svc_id | output | clog2(NUM_SRC+1) | Serviced source, NUM_SRC for the non-maskable line |
| resume_nosvc | output | 1 | Wake without any service |
| clk_stable | output | 1 | Oscillator usable |

## Verification
The wake decision is driven with requests above the mask, at or below the mask on ordinary sources, masked on wake-capable sources, and on the non-maskable line under the highest mask. These patterns separate a service wake, a resume without service and no wake at all. Requests timed inside and after the entry window separate held requests from waking ones. Pairs of held and new requests, with the new one or the held one ahead and with equal levels, expose the service order and the index tie-break. Stop release by reset is counted edge by edge against the warm-up length, and set against a reset out of an idle mode that carries a held request.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ENTRY = 2'd1,
        ST_HALT  = 2'd2,
        ST_WARM  = 2'd3
    } hwc_state_e;

    localparam logic [1:0] MODE_LIGHT = 2'd0;
    localparam logic [1:0] MODE_DEEP  = 2'd1;
    localparam logic [1:0] MODE_STOP  = 2'd2;

endpackage

// File: rtl/hwc_src_qual.sv
module hwc_src_qual #(
    parameter int              NUM_SRC  = 8,
    parameter int              LVL_W    = 3,
    parameter logic [NUM_SRC-1:0] WAKE_CAP = 8'h3F
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       irq_pend,
    input  logic [NUM_SRC*LVL_W-1:0] irq_lvl,
    input  logic [LVL_W-1:0]         mask_lvl,
    input  logic                     nmi,
    output logic [NUM_SRC-1:0]       svc_rise,
    output logic [NUM_SRC-1:0]       wc_rise,
    output logic                     nmi_rise
);

    logic [NUM_SRC-1:0] pend_d, pend_q;
    logic               nmi_d, nmi_q;

    always_comb begin
        pend_d = irq_pend;
        nmi_d  = nmi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            nmi_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            nmi_q  <= nmi_d;
        end
    end

    assign nmi_rise = nmi & ~nmi_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic             rise;
        logic             above;
        logic [LVL_W-1:0] lvl;
        assign lvl         = irq_lvl[g*LVL_W +: LVL_W];
        assign rise        = irq_pend[g] & ~pend_q[g];
        assign above       = lvl > mask_lvl;
        assign svc_rise[g] = rise & above;
        assign wc_rise[g]  = rise & ~above & WAKE_CAP[g];
    end

endmodule

// File: rtl/hwc_pick.sv
module hwc_pick #(
    parameter int NUM_SRC = 8,
    parameter int LVL_W   = 3,
    localparam int ID_W   = $clog2(NUM_SRC + 1),
    localparam int PRI_W  = LVL_W + 1
) (
    input  logic [NUM_SRC-1:0]       req,
    input  logic [NUM_SRC*LVL_W-1:0] irq_lvl,
    input  logic                     nmi_req,
    output logic                     win_vld,
    output logic [ID_W-1:0]          win_id,
    output logic [PRI_W-1:0]         win_pri
);

    localparam logic [PRI_W-1:0] NMI_PRI = {1'b1, {LVL_W{1'b0}}};

    always_comb begin
        win_vld = 1'b0;
        win_id  = '0;
        win_pri = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i] && (!win_vld || {1'b0, irq_lvl[i*LVL_W +: LVL_W]} > win_pri)) begin
                win_vld = 1'b1;
                win_id  = ID_W'(i);
                win_pri = {1'b0, irq_lvl[i*LVL_W +: LVL_W]};
            end
        end
        if (nmi_req) begin
            win_vld = 1'b1;
            win_id  = ID_W'(NUM_SRC);
            win_pri = NMI_PRI;
        end
    end

endmodule

// File: rtl/hwc_warm_timer.sv
module hwc_warm_timer #(
    parameter int  OSC_WAIT = 16,
    localparam int CNT_W    = $clog2(OSC_WAIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = CNT_W'(OSC_WAIT);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(OSC_WAIT));

endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl #(
    parameter int                 NUM_SRC   = 8,
    parameter int                 LVL_W     = 3,
    parameter int                 ENTRY_WIN = 5,
    parameter int                 OSC_WAIT  = 16,
    parameter logic [NUM_SRC-1:0] WAKE_CAP  = 8'h3F
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             soft_rst,
    input  logic                             halt_req,
    input  logic [1:0]                       halt_mode,
    input  logic [LVL_W-1:0]                 mask_lvl,
    input  logic [NUM_SRC-1:0]               irq_pend,
    input  logic [NUM_SRC*LVL_W-1:0]         irq_lvl,
    input  logic                             nmi,
    output logic                             halted,
    output logic                             wake_pulse,
    output logic                             svc_strobe,
    output logic [$clog2(NUM_SRC+1)-1:0]     svc_id,
    output logic                             resume_nosvc,
    output logic                             clk_stable
);

    import hwc_pkg::*;

    localparam int ID_W  = $clog2(NUM_SRC + 1);
    localparam int PRI_W = LVL_W + 1;
    localparam int WIN_W = $clog2(ENTRY_WIN + 1);

    typedef struct packed {
        hwc_state_e       st;
        logic [1:0]       mode;
        logic [WIN_W-1:0] win;
        logic             hold_vld;
        logic [ID_W-1:0]  hold_id;
        logic [PRI_W-1:0] hold_pri;
        logic             nxt_vld;
        logic [ID_W-1:0]  nxt_id;
        logic             wake;
        logic             svc;
        logic [ID_W-1:0]  svc_id;
        logic             nosvc;
    } ctl_t;

    ctl_t d, q;

    logic [NUM_SRC-1:0] svc_rise, wc_rise;
    logic               nmi_rise;
    logic               new_vld;
    logic [ID_W-1:0]    new_id;
    logic [PRI_W-1:0]   new_pri;
    logic               warm_load, warm_done;

    hwc_src_qual #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .WAKE_CAP(WAKE_CAP)) qual_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_pend (irq_pend),
        .irq_lvl  (irq_lvl),
        .mask_lvl (mask_lvl),
        .nmi      (nmi),
        .svc_rise (svc_rise),
        .wc_rise  (wc_rise),
        .nmi_rise (nmi_rise)
    );

    hwc_pick #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) pick_i (
        .req     (svc_rise),
        .irq_lvl (irq_lvl),
        .nmi_req (nmi_rise),
        .win_vld (new_vld),
        .win_id  (new_id),
        .win_pri (new_pri)
    );

    hwc_warm_timer #(.OSC_WAIT(OSC_WAIT)) warm_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (warm_load),
        .done  (warm_done)
    );

    function automatic logic outranks(input logic [PRI_W-1:0] pa, input logic [ID_W-1:0] ia,
                                      input logic [PRI_W-1:0] pb, input logic [ID_W-1:0] ib);
        return (pa > pb) || ((pa == pb) && (ia < ib));
    endfunction

    always_comb begin
        d       = q;
        d.wake  = 1'b0;
        d.svc   = 1'b0;
        d.nosvc = 1'b0;
        case (q.st)
            ST_RUN: begin
                if (q.nxt_vld) begin
                    d.svc     = 1'b1;
                    d.svc_id  = q.nxt_id;
                    d.nxt_vld = 1'b0;
                end
                if (halt_req) begin
                    d.mode     = halt_mode;
                    d.win      = '0;
                    d.hold_vld = 1'b0;
                    d.st       = (halt_mode == MODE_LIGHT) ? ST_HALT : ST_ENTRY;
                end
            end
            ST_ENTRY: begin
                if (new_vld && (!q.hold_vld || outranks(new_pri, new_id, q.hold_pri, q.hold_id))) begin
                    d.hold_vld = 1'b1;
                    d.hold_id  = new_id;
                    d.hold_pri = new_pri;
                end
                if (q.win == WIN_W'(ENTRY_WIN - 1))
                    d.st = ST_HALT;
                else
                    d.win = q.win + WIN_W'(1);
            end
            ST_HALT: begin
                if (new_vld) begin
                    d.st       = ST_RUN;
                    d.wake     = 1'b1;
                    d.svc      = 1'b1;
                    d.hold_vld = 1'b0;
                    d.nxt_vld  = q.hold_vld;
                    if (q.hold_vld && outranks(q.hold_pri, q.hold_id, new_pri, new_id)) begin
                        d.svc_id = q.hold_id;
                        d.nxt_id = new_id;
                    end else begin
                        d.svc_id = new_id;
                        d.nxt_id = q.hold_id;
                    end
                end else if (|wc_rise) begin
                    d.st       = ST_RUN;
                    d.wake     = 1'b1;
                    d.hold_vld = 1'b0;
                    if (q.hold_vld) begin
                        d.svc    = 1'b1;
                        d.svc_id = q.hold_id;
                    end else begin
                        d.nosvc = 1'b1;
                    end
                end
            end
            ST_WARM: begin
                if (warm_done)
                    d.st = ST_RUN;
            end
            default: d.st = ST_RUN;
        endcase
        if (soft_rst) begin
            d.st       = (q.st == ST_WARM ||
                          ((q.st == ST_ENTRY || q.st == ST_HALT) && q.mode[1])) ? ST_WARM : ST_RUN;
            d.hold_vld = 1'b0;
            d.nxt_vld  = 1'b0;
            d.wake     = 1'b0;
            d.svc      = 1'b0;
            d.nosvc    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_RUN, mode: '0, win: '0, hold_vld: 1'b0, hold_id: '0, hold_pri: '0,
                   nxt_vld: 1'b0, nxt_id: '0, wake: 1'b0, svc: 1'b0, svc_id: '0, nosvc: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign warm_load    = soft_rst && (d.st == ST_WARM);
    assign halted       = (q.st == ST_ENTRY) || (q.st == ST_HALT);
    assign wake_pulse   = q.wake;
    assign svc_strobe   = q.svc;
    assign svc_id       = q.svc_id;
    assign resume_nosvc = q.nosvc;
    assign clk_stable   = (q.st != ST_WARM) && !((q.st == ST_HALT) && q.mode[1]);

    // R1
    rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !halted);

    // R2
    halt_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(halt_req));

    // R3
    wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    // R3
    wake_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> !halted);

    // R6
    nosvc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_nosvc |-> (wake_pulse && !svc_strobe));

    // R8
    second_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN && q.nxt_vld && !soft_rst) |=> svc_strobe);

    // R10
    warm_unstable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WARM) |-> (!clk_stable && !halted));

endmodule

// File: tb/halt_wake_ctrl_tb.sv
module halt_wake_ctrl_tb_top;

    localparam int NUM_SRC   = 8;
    localparam int LVL_W     = 3;
    localparam int ENTRY_WIN = 5;
    localparam int OSC_WAIT  = 16;
    localparam int ID_W      = 4;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     soft_rst = 1'b0;
    logic                     halt_req = 1'b0;
    logic [1:0]               halt_mode = 2'd0;
    logic [LVL_W-1:0]         mask_lvl = '0;
    logic [NUM_SRC-1:0]       irq_pend = '0;
    logic [NUM_SRC*LVL_W-1:0] irq_lvl = '0;
    logic                     nmi = 1'b0;
    logic                     halted, wake_pulse, svc_strobe, resume_nosvc, clk_stable;
    logic [ID_W-1:0]          svc_id;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    halt_wake_ctrl #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .ENTRY_WIN(ENTRY_WIN),
                     .OSC_WAIT(OSC_WAIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .halt_req(halt_req),
        .halt_mode(halt_mode), .mask_lvl(mask_lvl), .irq_pend(irq_pend),
        .irq_lvl(irq_lvl), .nmi(nmi), .halted(halted), .wake_pulse(wake_pulse),
        .svc_strobe(svc_strobe), .svc_id(svc_id), .resume_nosvc(resume_nosvc),
        .clk_stable(clk_stable)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_lvl(input int src, input int v);
        irq_lvl[src*LVL_W +: LVL_W] = LVL_W'(v);
    endtask

    task automatic clear_all();
        irq_pend = '0;
        nmi      = 1'b0;
        soft_rst = 1'b0;
        step();
        step();
    endtask

    task automatic enter(input logic [1:0] mode, input bit wait_win);
        halt_mode = mode;
        halt_req  = 1'b1;
        step();
        halt_req  = 1'b0;
        check("R2 halted after request", int'(halted), 1);
        if (wait_win) repeat (ENTRY_WIN) step();
    endtask

    task automatic t_reset_state();
        check("R1 reset halted", int'(halted), 0);
        check("R10 reset clk_stable", int'(clk_stable), 1);
        check("R3 reset wake", int'(wake_pulse), 0);
        check("R3 reset svc", int'(svc_strobe), 0);
    endtask

    task automatic t_light_service();
        mask_lvl = 3'd2;
        set_lvl(3, 5);
        enter(2'd0, 1'b0);
        irq_pend[3] = 1'b1;
        step();
        check("R7 light idle no window wake", int'(wake_pulse), 1);
        check("R3 svc strobe", int'(svc_strobe), 1);
        check("R3 svc id", int'(svc_id), 3);
        check("R3 halted low", int'(halted), 0);
        check("R3 no nosvc", int'(resume_nosvc), 0);
        step();
        check("R3 wake one cycle", int'(wake_pulse), 0);
        check("R3 svc one cycle", int'(svc_strobe), 0);
        clear_all();
    endtask

    task automatic t_masked_then_nmi();
        mask_lvl = 3'd4;
        set_lvl(7, 1);
        set_lvl(6, 4);
        enter(2'd1, 1'b1);
        irq_pend[7] = 1'b1;
        irq_pend[6] = 1'b1;
        step();
        check("R4 masked stays halted", int'(halted), 1);
        check("R4 masked no wake", int'(wake_pulse), 0);
        check("R4 masked no svc", int'(svc_strobe), 0);
        step();
        check("R4 still halted", int'(halted), 1);
        mask_lvl = 3'd7;
        nmi = 1'b1;
        step();
        check("R5 nmi wake", int'(wake_pulse), 1);
        check("R5 nmi svc", int'(svc_strobe), 1);
        check("R5 nmi id", int'(svc_id), NUM_SRC);
        clear_all();
    endtask

    task automatic t_wakecap_stop();
        mask_lvl = 3'd3;
        set_lvl(2, 1);
        enter(2'd2, 1'b1);
        check("R10 stop halt clk_stable low", int'(clk_stable), 0);
        irq_pend[2] = 1'b1;
        step();
        check("R6 wake", int'(wake_pulse), 1);
        check("R6 nosvc", int'(resume_nosvc), 1);
        check("R6 no svc", int'(svc_strobe), 0);
        check("R6 halted low", int'(halted), 0);
        step();
        check("R6 nosvc one cycle", int'(resume_nosvc), 0);
        clear_all();
    endtask

    task automatic t_window_hold();
        mask_lvl = 3'd0;
        set_lvl(4, 3);
        set_lvl(1, 6);
        halt_mode = 2'd1;
        halt_req  = 1'b1;
        step();
        halt_req  = 1'b0;
        irq_pend[4] = 1'b1;
        step();
        check("R7 window no wake", int'(wake_pulse), 0);
        check("R7 window halted", int'(halted), 1);
        repeat (6) step();
        check("R7 held does not wake", int'(halted), 1);
        irq_pend[1] = 1'b1;
        step();
        check("R8 new higher wake", int'(wake_pulse), 1);
        check("R8 first id", int'(svc_id), 1);
        step();
        check("R8 second svc", int'(svc_strobe), 1);
        check("R8 second id", int'(svc_id), 4);
        step();
        check("R8 no third svc", int'(svc_strobe), 0);
        clear_all();
    endtask

    task automatic t_held_first();
        mask_lvl = 3'd0;
        set_lvl(5, 7);
        set_lvl(0, 2);
        halt_mode = 2'd2;
        halt_req  = 1'b1;
        step();
        halt_req  = 1'b0;
        irq_pend[5] = 1'b1;
        repeat (7) step();
        irq_pend[0] = 1'b1;
        step();
        check("R8 held first svc", int'(svc_strobe), 1);
        check("R8 held first id", int'(svc_id), 5);
        step();
        check("R8 new second id", int'(svc_id), 0);
        clear_all();
    endtask

    task automatic t_ties();
        mask_lvl = 3'd0;
        set_lvl(6, 2);
        set_lvl(3, 2);
        halt_mode = 2'd1;
        halt_req  = 1'b1;
        step();
        halt_req  = 1'b0;
        irq_pend[6] = 1'b1;
        repeat (7) step();
        irq_pend[3] = 1'b1;
        step();
        check("R9 tie held vs new lower id", int'(svc_id), 3);
        step();
        check("R9 tie second id", int'(svc_id), 6);
        clear_all();
        set_lvl(5, 4);
        set_lvl(2, 4);
        enter(2'd0, 1'b0);
        irq_pend[5] = 1'b1;
        irq_pend[2] = 1'b1;
        step();
        check("R9 simultaneous tie id", int'(svc_id), 2);
        step();
        check("R9 only winner served", int'(svc_strobe), 0);
        clear_all();
        set_lvl(7, 7);
        enter(2'd0, 1'b0);
        irq_pend[7] = 1'b1;
        nmi = 1'b1;
        step();
        check("R9 nmi outranks level 7", int'(svc_id), NUM_SRC);
        clear_all();
    endtask

    task automatic t_stop_reset();
        enter(2'd2, 1'b1);
        soft_rst = 1'b1;
        step();
        soft_rst = 1'b0;
        check("R1 reset ends stop", int'(halted), 0);
        check("R10 warm clk_stable low", int'(clk_stable), 0);
        halt_mode = 2'd0;
        halt_req  = 1'b1;
        step();
        halt_req  = 1'b0;
        check("R2 request ignored in warm-up", int'(halted), 0);
        repeat (OSC_WAIT - 1) step();
        check("R10 still warming", int'(clk_stable), 0);
        step();
        check("R10 stable after wait", int'(clk_stable), 1);
        check("R2 still running", int'(halted), 0);
        clear_all();
    endtask

    task automatic t_idle_reset_hold();
        mask_lvl = 3'd0;
        set_lvl(3, 5);
        halt_mode = 2'd1;
        halt_req  = 1'b1;
        step();
        halt_req  = 1'b0;
        irq_pend[3] = 1'b1;
        repeat (7) step();
        soft_rst = 1'b1;
        step();
        soft_rst = 1'b0;
        check("R1 reset ends idle", int'(halted), 0);
        check("R10 idle reset keeps stable", int'(clk_stable), 1);
        check("R1 reset no svc", int'(svc_strobe), 0);
        irq_pend = '0;
        step();
        set_lvl(7, 6);
        enter(2'd0, 1'b0);
        irq_pend[7] = 1'b1;
        step();
        check("R1 fresh svc id", int'(svc_id), 7);
        step();
        check("R1 held discarded", int'(svc_strobe), 0);
        clear_all();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset_state();
        t_light_service();
        t_masked_then_nmi();
        t_wakecap_stop();
        t_window_hold();
        t_held_first();
        t_ties();
        t_stop_reset();
        t_idle_reset_hold();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

endmodule